// File: doc/BRIEF.md
# Memory-Mapped 64-bit Compare Timer

The block keeps a free-running 64-bit up-counter and one 64-bit comparator, both reached by software through a 32-bit register port. The port is synchronous. A write strobe updates the addressed register at the clock edge. A read strobe loads the addressed register into a registered read-data output one cycle later. The counter is always live and is never latched. To get a consistent 64-bit count, software reads the high word, then the low word, then the high word again, and repeats the sequence if the two high words differ.

The comparator raises a sticky event flag when the count is greater than or equal to the comparator value. In one-shot use the comparator disarms after an event. It arms again only when a comparator word is written or when compare-enable goes from 0 to 1. In periodic use every event adds a 32-bit increment to the comparator. The interrupt output is a registered copy of the flag, gated by the interrupt enable. Clearing compare-enable around a comparator rewrite keeps the flag quiet while the two halves are in transition.

Top module: `tick_compare_timer`

## Requirements
- R1: Byte offsets: 0x00 count low, 0x04 count high, 0x08 control, 0x0C status, 0x10 comparator low, 0x14 comparator high, 0x18 increment. Read data appears on the cycle after the read strobe. Any other offset reads as zero.
- R2: Control bit 0 is run, bit 1 is compare-enable, bit 2 is interrupt-enable and bit 3 is auto-increment. All other control bits read as zero, bits 15:8 included.
- R3: While run is 1, the counter increases by one on every clock that carries no counter write, and it wraps from all ones to zero.
- R4: Both counter halves are writable. A write cycle does not advance the count, and with run at 0 the count holds.
- R5: Reads return the live count. Low-word reads one cycle apart differ by exactly 1 while running, and a carry between two high-word reads is visible to software.
- R6: With compare-enable at 1 and the comparator armed, status bit 0 sets when the count is greater than or equal to the comparator, as unsigned 64-bit values.
- R7: Writing status with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 leaves the flag unchanged.
- R8: Without auto-increment, an event disarms the comparator. A cleared flag stays clear until a comparator word is written or compare-enable is written from 0 to 1.
- R9: With auto-increment on, each event adds the zero-extended 32-bit increment to the 64-bit comparator.
- R10: While compare-enable is 0 the flag never sets, even when the count is at or above the comparator.
- R11: irq is a register equal to the flag ANDed with interrupt-enable, one cycle late.
- R12: Reset clears the counter, control, comparator, increment, flag and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a comparator that is at or below the count but disarmed or disabled. The flag must stay quiet there until a specific write arms it again. The bench stops the counter so that count and comparator are set exactly. It walks offsets of -3 to +3 around base values on both sides of the 32-bit carry. It then clears the flag, rewrites single comparator words and toggles compare-enable, and reads status after each step. Periodic mode is checked by letting the counter run a known number of cycles and then comparing the final comparator with the next multiple of the increment.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int OFS_CNT_LO = 'h00;
  localparam int OFS_CNT_HI = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_STAT   = 'h0C;
  localparam int OFS_CMP_LO = 'h10;
  localparam int OFS_CMP_HI = 'h14;
  localparam int OFS_INC    = 'h18;

  localparam int CB_RUN  = 0;
  localparam int CB_CMP  = 1;
  localparam int CB_IEN  = 2;
  localparam int CB_AUTO = 3;
  localparam int CTRL_W  = 4;

  typedef struct packed {
    logic auto_inc;
    logic irq_en;
    logic cmp_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W-1:0]   wdata,
  output logic [2*W-1:0] count
);
  localparam int CW = 2 * W;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) count[W-1:0]  <= wdata;
      if (wr_hi) count[CW-1:W] <= wdata;
    end else if (run) begin
      count <= count + CW'(1);
    end
  end

  // R3
  run_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run && !wr_lo && !wr_hi)) |-> (count == $past(count) + CW'(1)));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!run && !wr_lo && !wr_hi)) |-> $stable(count));
endmodule

// File: rtl/tct_compare.sv
module tct_compare #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] count,
  input  logic           cmp_en,
  input  logic           auto_en,
  input  logic [W-1:0]   inc,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W-1:0]   wdata,
  input  logic           arm,
  input  logic           clr,
  output logic [2*W-1:0] cmp_val,
  output logic           flag
);
  localparam int CW = 2 * W;

  logic armed;
  logic ev;

  assign ev = cmp_en && armed && (count >= cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '0;
      armed   <= 1'b1;
      flag    <= 1'b0;
    end else begin
      if (wr_lo || wr_hi) begin
        if (wr_lo) cmp_val[W-1:0]  <= wdata;
        if (wr_hi) cmp_val[CW-1:W] <= wdata;
      end else if (ev && auto_en) begin
        cmp_val <= cmp_val + CW'(inc);
      end

      if (arm)                 armed <= 1'b1;
      else if (ev && !auto_en) armed <= 1'b0;

      if (ev)       flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R10
  flag_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(flag)) |-> $past(cmp_en));

  // R6
  flag_needs_ge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(flag)) |-> $past(count >= cmp_val));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag && !clr)) |-> flag);

  // R8
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!armed && !arm)) |-> !$rose(flag));

  // R9
  auto_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ev && auto_en && !wr_lo && !wr_hi))
      |-> (cmp_val == $past(cmp_val) + CW'($past(inc))));
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import tct_pkg::*;

  localparam int CW = 2 * DATA_W;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] inc_q;
  logic [CW-1:0]     count;
  logic [CW-1:0]     cmp_val;
  logic              flag;

  logic sel_cnt_lo, sel_cnt_hi, sel_ctrl, sel_stat, sel_cmp_lo, sel_cmp_hi, sel_inc;
  logic hit;

  assign sel_cnt_lo = (bus_addr == ADDR_W'(OFS_CNT_LO));
  assign sel_cnt_hi = (bus_addr == ADDR_W'(OFS_CNT_HI));
  assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_stat   = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_cmp_lo = (bus_addr == ADDR_W'(OFS_CMP_LO));
  assign sel_cmp_hi = (bus_addr == ADDR_W'(OFS_CMP_HI));
  assign sel_inc    = (bus_addr == ADDR_W'(OFS_INC));
  assign hit = sel_cnt_lo | sel_cnt_hi | sel_ctrl | sel_stat | sel_cmp_lo | sel_cmp_hi | sel_inc;

  logic arm_req, clr_req;
  assign arm_req = bus_wr && (sel_cmp_lo || sel_cmp_hi ||
                   (sel_ctrl && bus_wdata[CB_CMP] && !ctrl_q.cmp_en));
  assign clr_req = bus_wr && sel_stat && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      inc_q  <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (sel_inc)  inc_q  <= bus_wdata;
    end
  end

  tct_counter #(.W(DATA_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (ctrl_q.run),
    .wr_lo (bus_wr && sel_cnt_lo),
    .wr_hi (bus_wr && sel_cnt_hi),
    .wdata (bus_wdata),
    .count (count)
  );

  tct_compare #(.W(DATA_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .count   (count),
    .cmp_en  (ctrl_q.cmp_en),
    .auto_en (ctrl_q.auto_inc),
    .inc     (inc_q),
    .wr_lo   (bus_wr && sel_cmp_lo),
    .wr_hi   (bus_wr && sel_cmp_hi),
    .wdata   (bus_wdata),
    .arm     (arm_req),
    .clr     (clr_req),
    .cmp_val (cmp_val),
    .flag    (flag)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag && ctrl_q.irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (sel_cnt_lo) bus_rdata <= count[DATA_W-1:0];
      if (sel_cnt_hi) bus_rdata <= count[CW-1:DATA_W];
      if (sel_ctrl)   bus_rdata <= DATA_W'(ctrl_q);
      if (sel_stat)   bus_rdata <= DATA_W'(flag);
      if (sel_cmp_lo) bus_rdata <= cmp_val[DATA_W-1:0];
      if (sel_cmp_hi) bus_rdata <= cmp_val[CW-1:DATA_W];
      if (sel_inc)    bus_rdata <= inc_q;
    end
  end

  // R11
  irq_from_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq) |-> $past(flag));

  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rd && !hit)) |-> (bus_rdata == '0));
endmodule

// File: tb/tick_compare_timer_test.sv
module tick_compare_timer_test;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  tick_compare_timer #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_count(input logic [63:0] v);
    wr('h00, v[31:0]); wr('h04, v[63:32]);
  endtask

  task automatic set_cmp(input logic [63:0] v);
    wr('h10, v[31:0]); wr('h14, v[63:32]);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, h1, h2;
    logic [63:0] base, c;
    int k;
    idle(3);
    rst = 1'b0;

    // R12 reset state, R1 offsets
    for (int a = 0; a <= 'h18; a += 4) begin
      rd(a, v);
      chk("R12 reset register", 64'(v), 64'd0);
    end
    chk("R12 reset irq", 64'(irq), 64'd0);

    // R1 unmapped offset, R2 control readback
    wr('h18, 32'hDEAD_BEEF);
    rd('h1C, v); chk("R1 unmapped offset", 64'(v), 64'd0);
    rd('h18, v); chk("R1 increment readback", 64'(v), 64'hDEAD_BEEF);
    wr('h08, 32'hFFFF_FFFF);
    wr('h08, 32'h0);
    wr('h08, 32'hFFFF_FF0F);
    rd('h08, v); chk("R2 control reads bits 3:0 only", 64'(v), 64'hF);
    wr('h08, 32'h0);

    // R4 writable halves, hold while stopped
    set_count(64'h0000_0012_3456_789A);
    idle(4);
    rd('h00, v); chk("R4 count low holds", 64'(v), 64'h3456_789A);
    rd('h04, v); chk("R4 count high holds", 64'(v), 64'h12);

    // R3 wrap from all ones
    set_count('1);
    wr('h08, 32'h1);
    wr('h08, 32'h0);
    rd('h00, v); chk("R3 wrap low", 64'(v), 64'd0);
    rd('h04, v); chk("R3 wrap high", 64'(v), 64'd0);

    // R5 live reads, high-low-high with carry
    set_count(64'h0000_0003_FFFF_FFFE);
    wr('h08, 32'h1);
    rd('h04, h1); rd('h00, v); rd('h04, h2);
    chk("R5 first high", 64'(h1), 64'd3);
    chk("R5 low before carry", 64'(v), 64'hFFFF_FFFF);
    chk("R5 carry seen on second high", 64'(h2), 64'd4);
    rd('h00, v); rd('h00, v2); rd('h04, h1);
    chk("R5 retry low", 64'(v), 64'd1);
    chk("R5 consecutive low step", 64'(v2 - v), 64'd1);
    chk("R5 retry high stable", 64'(h1), 64'd4);
    wr('h08, 32'h0);

    // R6 greater-or-equal sweep around three bases
    for (int b = 0; b < 3; b++) begin
      base = (b == 0) ? 64'd100 : (b == 1) ? 64'h1_0000_0000 : 64'h5_FFFF_FFFE;
      for (int d = -3; d <= 3; d++) begin
        c = base + 64'(signed'(d));
        wr('h08, 32'h0);
        set_count(base);
        wr('h0C, 32'h1);
        set_cmp(c);
        wr('h08, 32'h2);
        idle(1);
        rd('h0C, v);
        chk("R6 count >= comparator", 64'(v), (d <= 0) ? 64'd1 : 64'd0);
      end
    end

    // R11 irq follows flag with enable
    wr('h08, 32'h0);
    set_count(64'd50);
    wr('h0C, 32'h1);
    set_cmp(64'd40);
    wr('h08, 32'h2);
    idle(2);
    chk("R11 irq off while disabled", 64'(irq), 64'd0);
    wr('h08, 32'h6);
    idle(1);
    chk("R11 irq on", 64'(irq), 64'd1);

    // R7 write of zero ignored, write of one clears
    wr('h0C, 32'h0);
    idle(1);
    rd('h0C, v); chk("R7 write 0 keeps flag", 64'(v), 64'd1);
    wr('h0C, 32'h1);
    idle(2);
    rd('h0C, v); chk("R8 disarmed flag stays clear", 64'(v), 64'd0);
    chk("R11 irq drops with flag", 64'(irq), 64'd0);

    // R8 rearm by comparator write and by enable toggle
    wr('h10, 32'd40);
    idle(1);
    rd('h0C, v); chk("R8 rearm by comparator write", 64'(v), 64'd1);
    wr('h0C, 32'h1);
    wr('h08, 32'h4);
    wr('h08, 32'h6);
    idle(1);
    rd('h0C, v); chk("R8 rearm by enable toggle", 64'(v), 64'd1);

    // R10 no event with compare disabled during rewrite
    wr('h08, 32'h0);
    wr('h0C, 32'h1);
    set_cmp(64'd10);
    idle(3);
    rd('h0C, v); chk("R10 no flag while compare off", 64'(v), 64'd0);
    wr('h08, 32'h2);
    idle(1);
    rd('h0C, v); chk("R10 flag after enable", 64'(v), 64'd1);

    // R9 auto increment stepping past a stopped count, with carry
    wr('h08, 32'h0);
    set_count(64'd100);
    set_cmp(64'd90);
    wr('h18, 32'd5);
    wr('h08, 32'hA);
    idle(5);
    rd('h10, v); chk("R9 comparator steps to 105", 64'(v), 64'd105);
    wr('h08, 32'h0);
    set_count(64'h1_0000_0005);
    set_cmp(64'h0_FFFF_FFFE);
    wr('h18, 32'd4);
    wr('h08, 32'hA);
    idle(5);
    rd('h10, v); rd('h14, h1);
    chk("R9 carry into comparator high", {h1, v}, 64'h1_0000_0006);

    // R3 and R9 periodic events on a running counter
    wr('h08, 32'h0);
    set_count(64'd0);
    set_cmp(64'd10);
    wr('h18, 32'd10);
    wr('h08, 32'hB);
    idle(57);
    wr('h08, 32'hA);
    idle(2);
    rd('h00, v);
    k = int'(v);
    chk("R3 cycles counted", 64'(v), 64'd58);
    rd('h10, v);
    chk("R9 periodic comparator", 64'(v), 64'((k / 10 + 1) * 10));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule